// File: doc/BRIEF.md
# Dual-Write General Purpose I/O Port with Atomic Set/Clear

This block is a register-mapped general purpose I/O port that serves three pin groups: 12 input-only pins, 24 output-only pins and 6 bidirectional pins. Output latches are never written directly. Software raises bits through a set register and lowers them through a clear register. A 1 in the written word acts on the matching latch and a 0 leaves it alone, so any subset of pins changes in one write without a read-modify-write.

The block has two write channels, A and B, each with its own enable, address and data, so two bus masters can write in the same cycle. A combinational read channel returns three kinds of value: the latched output values, the per-bit direction of the bidirectional pins, and the live pin levels. Pin levels pass through a two-flop synchronizer before they are visible. The tristate pad of each bidirectional pin is modelled as an output-enable bit and an output-value bit. The pad's input is a separate port.

Top module: `pio_port`

## Requirements
- R1: A synchronous reset clears every output-only latch, every bidirectional output latch and every direction bit. After reset, `out_pin`, `bio_o` and `bio_oe` are all 0.
- R2: A write to address 0 (output-only set) forces to 1 every output-only latch whose data bit is 1 and leaves the others unchanged. The result is visible on `out_pin` after the next rising edge.
- R3: A write to address 1 (output-only clear) forces to 0 every output-only latch whose data bit is 1 and leaves the others unchanged.
- R4: Addresses 2 (set) and 3 (clear) act the same way on the 6 bidirectional output latches, which drive `bio_o`.
- R5: When one channel sets a latch bit and the other channel clears the same bit in the same cycle, the bit becomes 1. Bits set by both channels in the same cycle are combined by OR.
- R6: A write to address 4 loads data bits [5:0] into the direction register. A direction bit of 1 drives the pin (`bio_oe` = 1) and 0 makes it an input. If both channels write address 4 in the same cycle, the value from channel A is loaded.
- R7: Reading address 0 or 1 returns the output-only latches, zero-extended. Reading address 2 or 3 returns the bidirectional output latches, and reading address 4 returns the direction register.
- R8: Reading address 6 returns `in_pin`, and reading address 5 returns `bio_i` for every direction setting. Each value is the pin level sampled two rising edges earlier: after one edge the read still shows the old level, and after two edges it shows the new level.
- R9: Reading address 7 returns 0. Writes to addresses 5, 6 and 7 change no latch and no direction bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wa_en | input | 1 | Write channel A enable |
| wa_addr | input | 3 | Write channel A register address |
| wa_data | input | 32 | Write channel A data |
| wb_en | input | 1 | Write channel B enable |
| wb_addr | input | 3 | Write channel B register address |
| wb_data | input | 32 | Write channel B data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data (combinational) |
| in_pin | input | 12 | Input-only pin levels |
| out_pin | output | 24 | Output-only pin values |
| bio_i | input | 6 | Bidirectional pad input levels |
| bio_o | output | 6 | Bidirectional pad output values |
| bio_oe | output | 6 | Bidirectional pad output enables |

## Verification
The hardest condition to reach is a set and a clear on the same latch bit in the same clock. It arises only when both write channels are enabled together, one addressing a set register and the other the matching clear register. The stimulus drives that pairing in both channel orders, on both latch groups, with overlapping pseudo-random masks. The direction conflict, with both channels writing address 4, and the one-edge-late pin read are covered by dedicated sweeps that sample between the first and second edge after a pin change.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int REG_AW = 3;
  localparam int WORD_W = 32;

  typedef enum logic [REG_AW-1:0] {
    RA_OUT_SET = 3'd0,
    RA_OUT_CLR = 3'd1,
    RA_BIO_SET = 3'd2,
    RA_BIO_CLR = 3'd3,
    RA_DIR     = 3'd4,
    RA_BIO_LVL = 3'd5,
    RA_IN_LVL  = 3'd6,
    RA_VOID    = 3'd7
  } pio_reg_e;

  // next latch value: clear first, then set, so set wins on overlap
  function automatic logic [WORD_W-1:0] latch_next(
    input logic [WORD_W-1:0] cur,
    input logic [WORD_W-1:0] set_m,
    input logic [WORD_W-1:0] clr_m);
    return (cur & ~clr_m) | set_m;
  endfunction

  // gated mask: data when selected, zero otherwise
  function automatic logic [WORD_W-1:0] gate_mask(
    input logic                sel,
    input logic [WORD_W-1:0]   data);
    return sel ? data : '0;
  endfunction
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk) begin
    meta_q <= d;
    stab_q <= meta_q;
  end

  assign q = stab_q;
endmodule

// File: rtl/pio_wdec.sv
module pio_wdec
  import pio_pkg::*;
#(
  parameter int OUT_W = 24,
  parameter int BIO_W = 6
) (
  input  logic              en,
  input  logic [REG_AW-1:0] addr,
  input  logic [WORD_W-1:0] data,
  output logic [OUT_W-1:0]  out_set,
  output logic [OUT_W-1:0]  out_clr,
  output logic [BIO_W-1:0]  bio_set,
  output logic [BIO_W-1:0]  bio_clr,
  output logic              dir_we,
  output logic [BIO_W-1:0]  dir_val
);
  assign out_set = OUT_W'(gate_mask(en && addr == RA_OUT_SET, data));
  assign out_clr = OUT_W'(gate_mask(en && addr == RA_OUT_CLR, data));
  assign bio_set = BIO_W'(gate_mask(en && addr == RA_BIO_SET, data));
  assign bio_clr = BIO_W'(gate_mask(en && addr == RA_BIO_CLR, data));
  assign dir_we  = en && addr == RA_DIR;
  assign dir_val = BIO_W'(gate_mask(1'b1, data));
endmodule

// File: rtl/pio_setclr.sv
module pio_setclr
  import pio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_m,
  input  logic [W-1:0] clr_m,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;

  always_ff @(posedge clk) begin
    if (rst) q_r <= '0;
    else     q_r <= W'(latch_next(WORD_W'(q_r), WORD_W'(set_m), WORD_W'(clr_m)));
  end

  assign q = q_r;
endmodule

// File: rtl/pio_port.sv
module pio_port
  import pio_pkg::*;
#(
  parameter int IN_W  = 12,
  parameter int OUT_W = 24,
  parameter int BIO_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wa_en,
  input  logic [REG_AW-1:0] wa_addr,
  input  logic [WORD_W-1:0] wa_data,
  input  logic              wb_en,
  input  logic [REG_AW-1:0] wb_addr,
  input  logic [WORD_W-1:0] wb_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  input  logic [IN_W-1:0]   in_pin,
  output logic [OUT_W-1:0]  out_pin,
  input  logic [BIO_W-1:0]  bio_i,
  output logic [BIO_W-1:0]  bio_o,
  output logic [BIO_W-1:0]  bio_oe
);
  localparam int NCH = 2;

  logic              ch_en   [NCH];
  logic [REG_AW-1:0] ch_addr [NCH];
  logic [WORD_W-1:0] ch_data [NCH];

  assign ch_en[0]   = wa_en;
  assign ch_addr[0] = wa_addr;
  assign ch_data[0] = wa_data;
  assign ch_en[1]   = wb_en;
  assign ch_addr[1] = wb_addr;
  assign ch_data[1] = wb_data;

  logic [OUT_W-1:0] ch_out_set [NCH];
  logic [OUT_W-1:0] ch_out_clr [NCH];
  logic [BIO_W-1:0] ch_bio_set [NCH];
  logic [BIO_W-1:0] ch_bio_clr [NCH];
  logic             ch_dir_we  [NCH];
  logic [BIO_W-1:0] ch_dir_val [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pio_wdec #(.OUT_W(OUT_W), .BIO_W(BIO_W)) u_dec (
      .en      (ch_en[g]),
      .addr    (ch_addr[g]),
      .data    (ch_data[g]),
      .out_set (ch_out_set[g]),
      .out_clr (ch_out_clr[g]),
      .bio_set (ch_bio_set[g]),
      .bio_clr (ch_bio_clr[g]),
      .dir_we  (ch_dir_we[g]),
      .dir_val (ch_dir_val[g])
    );
  end

  // merged update events, named for the checker
  logic [OUT_W-1:0] out_set_m, out_clr_m;
  logic [BIO_W-1:0] bio_set_m, bio_clr_m;
  logic             dir_we;
  logic [BIO_W-1:0] dir_val;

  assign out_set_m = ch_out_set[0] | ch_out_set[1];
  assign out_clr_m = ch_out_clr[0] | ch_out_clr[1];
  assign bio_set_m = ch_bio_set[0] | ch_bio_set[1];
  assign bio_clr_m = ch_bio_clr[0] | ch_bio_clr[1];
  assign dir_we    = ch_dir_we[0] | ch_dir_we[1];
  assign dir_val   = ch_dir_we[0] ? ch_dir_val[0] : ch_dir_val[1];

  pio_setclr #(.W(OUT_W)) u_out_latch (
    .clk (clk), .rst (rst), .set_m (out_set_m), .clr_m (out_clr_m), .q (out_pin)
  );

  pio_setclr #(.W(BIO_W)) u_bio_latch (
    .clk (clk), .rst (rst), .set_m (bio_set_m), .clr_m (bio_clr_m), .q (bio_o)
  );

  logic [BIO_W-1:0] dir_q;
  always_ff @(posedge clk) begin
    if (rst)         dir_q <= '0;
    else if (dir_we) dir_q <= dir_val;
  end
  assign bio_oe = dir_q;

  logic [IN_W-1:0]  in_lvl;
  logic [BIO_W-1:0] bio_lvl;

  pio_sync #(.W(IN_W))  u_in_sync  (.clk (clk), .d (in_pin), .q (in_lvl));
  pio_sync #(.W(BIO_W)) u_bio_sync (.clk (clk), .d (bio_i),  .q (bio_lvl));

  always_comb begin
    case (rd_addr)
      RA_OUT_SET, RA_OUT_CLR: rd_data = WORD_W'(out_pin);
      RA_BIO_SET, RA_BIO_CLR: rd_data = WORD_W'(bio_o);
      RA_DIR:                 rd_data = WORD_W'(dir_q);
      RA_BIO_LVL:             rd_data = WORD_W'(bio_lvl);
      RA_IN_LVL:              rd_data = WORD_W'(in_lvl);
      default:                rd_data = '0;
    endcase
  end
endmodule

// File: rtl/pio_port_chk.sv
module pio_port_chk
  import pio_pkg::*;
#(
  parameter int IN_W  = 12,
  parameter int OUT_W = 24,
  parameter int BIO_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [REG_AW-1:0] rd_addr,
  input logic [WORD_W-1:0] rd_data,
  input logic [IN_W-1:0]   in_pin,
  input logic [IN_W-1:0]   in_lvl,
  input logic [OUT_W-1:0]  out_pin,
  input logic [BIO_W-1:0]  bio_o,
  input logic [BIO_W-1:0]  bio_oe,
  input logic [OUT_W-1:0]  out_set_m,
  input logic [OUT_W-1:0]  out_clr_m,
  input logic [BIO_W-1:0]  bio_set_m,
  input logic [BIO_W-1:0]  bio_clr_m,
  input logic              dir_we,
  input logic [BIO_W-1:0]  dir_val
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (out_pin == '0 && bio_o == '0 && bio_oe == '0));

  // R2
  out_set_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((out_pin & $past(out_set_m)) == $past(out_set_m)));

  // R5
  out_clr_lose_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((out_pin & $past(out_clr_m & ~out_set_m)) == '0));

  // R3
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((out_pin & ~$past(out_set_m | out_clr_m)) ==
              ($past(out_pin) & ~$past(out_set_m | out_clr_m))));

  // R4
  bio_setclr_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((bio_o & $past(bio_set_m)) == $past(bio_set_m)) &&
              ((bio_o & $past(bio_clr_m & ~bio_set_m)) == '0)));

  // R6
  dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !dir_we |=> $stable(bio_oe));

  // R6
  dir_load_chk: assert property (@(posedge clk) disable iff (rst)
    dir_we |=> (bio_oe == $past(dir_val)));

  // R8
  in_sync_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (in_lvl == $past(in_pin, 2)));

  // R9
  void_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == RA_VOID) |-> (rd_data == '0));
endmodule

bind pio_port pio_port_chk #(.IN_W(IN_W), .OUT_W(OUT_W), .BIO_W(BIO_W)) u_chk (.*);

// File: tb/pio_port_bench.sv
module pio_port_bench;
  localparam int CLK_NS = 10;
  localparam int IN_W = 12, OUT_W = 24, BIO_W = 6;

  logic clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic rst;
  logic wa_en, wb_en;
  logic [2:0] wa_addr, wb_addr, rd_addr;
  logic [31:0] wa_data, wb_data, rd_data;
  logic [IN_W-1:0] in_pin;
  logic [OUT_W-1:0] out_pin;
  logic [BIO_W-1:0] bio_i, bio_o, bio_oe;

  pio_port u_pio_port (
    .clk (clk), .rst (rst),
    .wa_en (wa_en), .wa_addr (wa_addr), .wa_data (wa_data),
    .wb_en (wb_en), .wb_addr (wb_addr), .wb_data (wb_data),
    .rd_addr (rd_addr), .rd_data (rd_data),
    .in_pin (in_pin), .out_pin (out_pin),
    .bio_i (bio_i), .bio_o (bio_o), .bio_oe (bio_oe)
  );

  int n_vec = 0;
  int n_bad = 0;
  logic [OUT_W-1:0] m_out;
  logic [BIO_W-1:0] m_bio, m_dir;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic wr2(input logic ae, input logic [2:0] aa, input logic [31:0] ad,
                     input logic be, input logic [2:0] ba, input logic [31:0] bd);
    @(negedge clk);
    wa_en = ae; wa_addr = aa; wa_data = ad;
    wb_en = be; wb_addr = ba; wb_data = bd;
    @(negedge clk);
    wa_en = 1'b0; wb_en = 1'b0;
  endtask

  task automatic check_state(input string req);
    logic [31:0] v;
    chk({req, " out_pin"}, 32'(out_pin), 32'(m_out));
    chk({req, " bio_o"},   32'(bio_o),   32'(m_bio));
    chk({req, " bio_oe"},  32'(bio_oe),  32'(m_dir));
    rd(3'd0, v); chk({req, " R7 rd0"}, v, 32'(m_out));
    rd(3'd1, v); chk({req, " R7 rd1"}, v, 32'(m_out));
    rd(3'd2, v); chk({req, " R7 rd2"}, v, 32'(m_bio));
    rd(3'd3, v); chk({req, " R7 rd3"}, v, 32'(m_bio));
    rd(3'd4, v); chk({req, " R7 rd4"}, v, 32'(m_dir));
    rd(3'd7, v); chk({req, " R9 rd7"}, v, 32'h0);
  endtask

  function automatic logic [31:0] pat(input int i);
    return (32'(i) * 32'h9E37_79B1) ^ (32'(i) << 13) ^ 32'h5A5A_0F0F;
  endfunction

  initial begin
    #(CLK_NS * 200000);
    n_bad++;
    $display("FAIL watchdog actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [IN_W-1:0] prev_in;
    logic [BIO_W-1:0] prev_bio;
    rst = 1'b1; wa_en = 1'b0; wb_en = 1'b0;
    wa_addr = '0; wb_addr = '0; wa_data = '0; wb_data = '0; rd_addr = '0;
    in_pin = '0; bio_i = '0;
    m_out = '0; m_bio = '0; m_dir = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check_state("R1");

    // R2 / R3: pseudo-random set then clear on output-only latches
    for (int i = 0; i < 40; i++) begin
      wr2(1'b1, 3'd0, pat(i), 1'b0, 3'd0, 32'h0);
      m_out = m_out | OUT_W'(pat(i));
      check_state("R2");
      wr2(1'b0, 3'd0, 32'h0, 1'b1, 3'd1, pat(i + 100));
      m_out = m_out & ~OUT_W'(pat(i + 100));
      check_state("R3");
    end

    // R2 / R3: walking single bits
    for (int b = 0; b < OUT_W; b++) begin
      wr2(1'b1, 3'd0, 32'h1 << b, 1'b0, 3'd0, 32'h0);
      m_out = m_out | OUT_W'(32'h1 << b);
      chk("R2 walk", 32'(out_pin), 32'(m_out));
      wr2(1'b1, 3'd1, 32'h1 << b, 1'b0, 3'd0, 32'h0);
      m_out = m_out & ~OUT_W'(32'h1 << b);
      chk("R3 walk", 32'(out_pin), 32'(m_out));
    end

    // R4: bidirectional latches, exhaustive set values
    for (int i = 0; i < 64; i++) begin
      wr2(1'b1, 3'd2, 32'(i), 1'b0, 3'd0, 32'h0);
      m_bio = m_bio | BIO_W'(i);
      check_state("R4 set");
      wr2(1'b0, 3'd0, 32'h0, 1'b1, 3'd3, pat(i));
      m_bio = m_bio & ~BIO_W'(pat(i));
      check_state("R4 clr");
    end

    // R5: same-cycle set and clear from different channels
    for (int i = 0; i < 32; i++) begin
      wr2(1'b1, 3'd0, pat(i), 1'b1, 3'd1, pat(i) | pat(i + 7));
      m_out = (m_out & ~OUT_W'(pat(i) | pat(i + 7))) | OUT_W'(pat(i));
      check_state("R5 out");
      wr2(1'b1, 3'd3, pat(i + 3), 1'b1, 3'd2, pat(i + 3) & pat(i + 9));
      m_bio = (m_bio & ~BIO_W'(pat(i + 3))) | BIO_W'(pat(i + 3) & pat(i + 9));
      check_state("R5 bio");
      wr2(1'b1, 3'd0, pat(i + 20), 1'b1, 3'd0, pat(i + 21));
      m_out = m_out | OUT_W'(pat(i + 20) | pat(i + 21));
      check_state("R5 or");
    end

    // R6: direction register, every value, then channel conflict
    for (int i = 0; i < 64; i++) begin
      wr2(1'b0, 3'd0, 32'h0, 1'b1, 3'd4, 32'(i) | 32'hFFFF_FF00);
      m_dir = BIO_W'(i);
      check_state("R6 dir");
    end
    for (int i = 0; i < 16; i++) begin
      wr2(1'b1, 3'd4, pat(i), 1'b1, 3'd4, ~pat(i));
      m_dir = BIO_W'(pat(i));
      check_state("R6 conflict");
    end

    // R8: synchronized pin reads, one edge late then current
    prev_in = in_pin; prev_bio = bio_i;
    for (int i = 0; i < 32; i++) begin
      if (i == 16) begin
        wr2(1'b1, 3'd4, 32'h0, 1'b0, 3'd0, 32'h0);
        m_dir = '0;
      end
      @(negedge clk);
      in_pin = IN_W'(pat(i + 50));
      bio_i  = BIO_W'(pat(i + 60));
      @(negedge clk);
      rd(3'd6, v); chk("R8 in one edge", v, 32'(prev_in));
      rd(3'd5, v); chk("R8 bio one edge", v, 32'(prev_bio));
      @(negedge clk);
      rd(3'd6, v); chk("R8 in two edges", v, 32'(in_pin));
      rd(3'd5, v); chk("R8 bio two edges", v, 32'(bio_i));
      chk("R8 bio_oe", 32'(bio_oe), 32'(m_dir));
      prev_in = in_pin; prev_bio = bio_i;
    end

    // R9: writes to read-only and unmapped addresses change nothing
    wr2(1'b1, 3'd5, 32'hFFFF_FFFF, 1'b1, 3'd6, 32'hFFFF_FFFF);
    check_state("R9 ro");
    wr2(1'b1, 3'd7, 32'hFFFF_FFFF, 1'b1, 3'd7, 32'h0);
    check_state("R9 void");
    wr2(1'b1, 3'd6, 32'h0, 1'b1, 3'd5, 32'h0);
    check_state("R9 ro zero");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule